// File: doc/BRIEF.md
# AV/C Tape Transport Command Handler

This block sits behind the node's transaction layer. It takes single-quadlet writes aimed at the AV/C command register and decodes each one as a complete command frame. A frame carries the command/transaction set code, the command type, the subunit address, the opcode and one operand byte. The block checks each field and then acts on the frame. It can move a small tape-transport state machine between stop, play, record, rewind and fast forward. It can load or report one of two signal-mode registers, one for the output plug and one for the input plug. It also answers the two general unit queries.

Every handled frame produces exactly one response quadlet, issued as a write to the response register address one clock after the command write. The response repeats the subunit and opcode bytes of the command. The command-type nibble is replaced by a response code. The operand byte is either echoed back or replaced by a reported value. The transport state and both signal modes are brought out as status outputs.

Top module: `avcVcrHandler`

## Requirements
- R1: After reset the transport state is STOP (code 0), both signal-mode registers hold 80 hex, and no response write is issued.
- R2: A frame is handled only when cmdWrValid is high, cmdWrAddr equals FFFF_F000_0B00 hex and the set-code nibble (data bits 31:28) is 0. Any other write produces no response and changes no state.
- R3: Frame layout is as follows. Bits 27:24 hold the command type (0 is control, 1 is status). Bits 23:16 hold the subunit address (type in 23:19, ID in 18:16). Bits 15:8 hold the opcode and bits 7:0 the operand. The response is issued on the clock after the command write. It goes to address FFFF_F000_0D00 hex with data {4'h0, response code, command bits 23:8, operand byte}, and each frame causes at most one state update.
- R4: A control frame to the tape subunit (address byte 20 hex) with opcode C3 hex and operand 38 hex is accepted (code 9) and sets the state to PLAY (1). Any other operand is rejected (code A) and leaves the state unchanged.
- R5: A control frame to the tape subunit with opcode C2 hex is accepted only with operand 75 hex, which sets the state to RECORD (2). Any other operand is rejected and changes nothing.
- R6: A control frame to the tape subunit with opcode C4 hex accepts operand 60 hex (STOP, 0), 65 hex (REWIND, 3) or 75 hex (FAST FORWARD, 4). Any other operand is rejected and changes nothing.
- R7: A control frame to the tape subunit with opcode 78 hex loads the output signal mode, and with opcode 79 hex loads the input signal mode. Only the codes 10, 14, 18, 80, 90, 94 and 98 hex are accepted. Any other code is rejected and leaves the register unchanged, so each register always holds a legal code.
- R8: A status frame to the tape subunit with opcode 78 or 79 hex gets a stable answer (code C). Its operand byte is the current output or input signal mode, and no state changes.
- R9: A status frame addressed to the unit (address byte FF hex) with opcode 30 hex or 31 hex gets a stable answer. Its operand byte is 20 hex, which reports one tape subunit with ID 0.
- R10: Any other handled frame gets a not-implemented answer (code 8) with the operand echoed, and changes no state. This covers an unknown opcode, a tape opcode with a wrong subunit address, transport opcodes with a command type other than control, signal-mode opcodes with a command type other than control or status, and unit queries that are not status frames to FF hex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdWrValid | input | 1 | Quadlet write strobe from the transaction layer |
| cmdWrAddr | input | 48 | Register address of the write |
| cmdWrData | input | 32 | Quadlet written (one command frame) |
| rspWrValid | output | 1 | Response write strobe, high for one cycle |
| rspWrAddr | output | 48 | Response register address |
| rspWrData | output | 32 | Response frame quadlet |
| xportState | output | 3 | Transport state: 0 stop, 1 play, 2 record, 3 rewind, 4 fast forward |
| outSignalMode | output | 8 | Output plug signal-mode code |
| inSignalMode | output | 8 | Input plug signal-mode code |

## Verification
The bench sends operand values one step away from the legal ones: 39 hex for play, 38 hex for record, 61 hex for wind and 81 hex for a mode. A design that decodes too loosely would change state on these frames, and the bench sees the wrong response code on the state outputs. It sends a frame with a nonzero set code and a write to the response address. A design that skips the address or set-code check would answer them. It also sends frames with a good opcode but the wrong subunit address or command type. A design that checks only the opcode would return accepted instead of not implemented. Back-to-back writes and status queries after mode loads show whether the response carries the right frame's echo bytes and the value stored at that point.

// File: rtl/avcVcrPkg.sv
package avcVcrPkg;

  localparam int BYTE_W = 8;

  // transport states, encoding visible on the xportState port
  typedef enum logic [2:0] {
    XPORT_STOP   = 3'd0,
    XPORT_PLAY   = 3'd1,
    XPORT_RECORD = 3'd2,
    XPORT_REWIND = 3'd3,
    XPORT_FFWD   = 3'd4
  } xportE;

  // source of the response operand byte
  typedef enum logic [1:0] {
    OPSEL_ECHO     = 2'd0,
    OPSEL_OUTMODE  = 2'd1,
    OPSEL_INMODE   = 2'd2,
    OPSEL_UNITDESC = 2'd3
  } opSelE;

  // strobes from control to datapath, one set per handled frame
  typedef struct packed {
    logic       respond;
    logic [3:0] rcode;
    opSelE      opSel;
    logic       loadXport;
    xportE      nextXport;
    logic       loadOutMode;
    logic       loadInMode;
  } ctrlStrobeT;

  // command types
  localparam logic [3:0] CT_CONTROL = 4'h0;
  localparam logic [3:0] CT_STATUS  = 4'h1;

  // response codes
  localparam logic [3:0] RC_NOTIMPL = 4'h8;
  localparam logic [3:0] RC_ACCEPT  = 4'h9;
  localparam logic [3:0] RC_REJECT  = 4'hA;
  localparam logic [3:0] RC_STABLE  = 4'hC;

  // opcodes
  localparam logic [7:0] OP_UNITINFO = 8'h30;
  localparam logic [7:0] OP_SUBINFO  = 8'h31;
  localparam logic [7:0] OP_OUTMODE  = 8'h78;
  localparam logic [7:0] OP_INMODE   = 8'h79;
  localparam logic [7:0] OP_RECORD   = 8'hC2;
  localparam logic [7:0] OP_PLAY     = 8'hC3;
  localparam logic [7:0] OP_WIND     = 8'hC4;

  // operands
  localparam logic [7:0] PLAY_X1    = 8'h38;
  localparam logic [7:0] RECORD_X1  = 8'h75;
  localparam logic [7:0] WIND_STOP  = 8'h60;
  localparam logic [7:0] WIND_REW   = 8'h65;
  localparam logic [7:0] WIND_FFWD  = 8'h75;

  // subunit addressing
  localparam logic [4:0] TAPE_TYPE   = 5'd4;
  localparam logic [2:0] TAPE_ID     = 3'd0;
  localparam logic [7:0] UNIT_ADDR   = 8'hFF;
  localparam logic [7:0] MODE_RESET  = 8'h80;

  function automatic logic isLegalMode(input logic [7:0] code);
    case (code)
      8'h10, 8'h14, 8'h18, 8'h80, 8'h90, 8'h94, 8'h98: isLegalMode = 1'b1;
      default:                                          isLegalMode = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/avcFrameCtrl.sv
module avcFrameCtrl
  import avcVcrPkg::*;
#(
  parameter int                ADDR_W   = 48,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 48'hFFFF_F000_0B00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output ctrlStrobeT        strb
);

  logic [3:0] setCode;
  logic [3:0] ctype;
  logic [7:0] subAddr;
  logic [7:0] opcode;
  logic [7:0] operand;
  logic       frameHit;
  logic       toTape;
  logic       toUnit;
  logic       isControl;
  logic       isStatus;

  assign setCode  = wrData[31:28];
  assign ctype    = wrData[27:24];
  assign subAddr  = wrData[23:16];
  assign opcode   = wrData[15:8];
  assign operand  = wrData[7:0];

  assign frameHit  = wrValid && (wrAddr == CMD_ADDR) && (setCode == 4'h0);
  assign toTape    = (subAddr == {TAPE_TYPE, TAPE_ID});
  assign toUnit    = (subAddr == UNIT_ADDR);
  assign isControl = (ctype == CT_CONTROL);
  assign isStatus  = (ctype == CT_STATUS);

  always_comb begin
    strb           = '0;
    strb.opSel     = OPSEL_ECHO;
    strb.nextXport = XPORT_STOP;
    strb.rcode     = RC_NOTIMPL;
    if (frameHit) begin
      strb.respond = 1'b1;
      case (opcode)
        OP_PLAY: begin
          if (toTape && isControl) begin
            if (operand == PLAY_X1) begin
              strb.rcode     = RC_ACCEPT;
              strb.loadXport = 1'b1;
              strb.nextXport = XPORT_PLAY;
            end else begin
              strb.rcode = RC_REJECT;
            end
          end
        end
        OP_RECORD: begin
          if (toTape && isControl) begin
            if (operand == RECORD_X1) begin
              strb.rcode     = RC_ACCEPT;
              strb.loadXport = 1'b1;
              strb.nextXport = XPORT_RECORD;
            end else begin
              strb.rcode = RC_REJECT;
            end
          end
        end
        OP_WIND: begin
          if (toTape && isControl) begin
            strb.rcode     = RC_ACCEPT;
            strb.loadXport = 1'b1;
            case (operand)
              WIND_STOP: strb.nextXport = XPORT_STOP;
              WIND_REW:  strb.nextXport = XPORT_REWIND;
              WIND_FFWD: strb.nextXport = XPORT_FFWD;
              default: begin
                strb.rcode     = RC_REJECT;
                strb.loadXport = 1'b0;
              end
            endcase
          end
        end
        OP_OUTMODE, OP_INMODE: begin
          if (toTape && isControl) begin
            if (isLegalMode(operand)) begin
              strb.rcode = RC_ACCEPT;
              if (opcode == OP_OUTMODE) strb.loadOutMode = 1'b1;
              else                      strb.loadInMode  = 1'b1;
            end else begin
              strb.rcode = RC_REJECT;
            end
          end else if (toTape && isStatus) begin
            strb.rcode = RC_STABLE;
            strb.opSel = (opcode == OP_OUTMODE) ? OPSEL_OUTMODE : OPSEL_INMODE;
          end
        end
        OP_UNITINFO, OP_SUBINFO: begin
          if (toUnit && isStatus) begin
            strb.rcode = RC_STABLE;
            strb.opSel = OPSEL_UNITDESC;
          end
        end
        default: ;
      endcase
    end
  end

  // R3
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.loadXport, strb.loadOutMode, strb.loadInMode}));

  // R3
  action_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.loadXport || strb.loadOutMode || strb.loadInMode) |->
      (strb.respond && strb.rcode == RC_ACCEPT));

endmodule

// File: rtl/avcVcrDatapath.sv
module avcVcrDatapath
  import avcVcrPkg::*;
#(
  parameter int MODE_CNT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  ctrlStrobeT strb,
  input  logic [15:0] echoBytes,
  input  logic [7:0]  operand,
  output logic        rspValid,
  output logic [31:0] rspData,
  output xportE       xport,
  output logic [7:0]  outMode,
  output logic [7:0]  inMode
);

  localparam int MODE_IDX_OUT = 0;
  localparam int MODE_IDX_IN  = 1;

  logic [MODE_CNT-1:0] modeLoad;
  logic [7:0]          modeReg [MODE_CNT];
  logic [7:0]          operandOut;

  assign modeLoad[MODE_IDX_OUT] = strb.loadOutMode;
  assign modeLoad[MODE_IDX_IN]  = strb.loadInMode;

  genvar g;
  generate
    for (g = 0; g < MODE_CNT; g++) begin : gMode
      always_ff @(posedge clk) begin
        if (!rst_n)           modeReg[g] <= MODE_RESET;
        else if (modeLoad[g]) modeReg[g] <= operand;
      end

      // R7
      legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isLegalMode(modeReg[g]));
    end
  endgenerate

  assign outMode = modeReg[MODE_IDX_OUT];
  assign inMode  = modeReg[MODE_IDX_IN];

  always_ff @(posedge clk) begin
    if (!rst_n)              xport <= XPORT_STOP;
    else if (strb.loadXport) xport <= strb.nextXport;
  end

  always_comb begin
    case (strb.opSel)
      OPSEL_OUTMODE:  operandOut = outMode;
      OPSEL_INMODE:   operandOut = inMode;
      OPSEL_UNITDESC: operandOut = {TAPE_TYPE, TAPE_ID};
      default:        operandOut = operand;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.respond;
      if (strb.respond) rspData <= {4'h0, strb.rcode, echoBytes, operandOut};
    end
  end

  // R4
  xport_change_accepted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(xport) |-> (rspValid && rspData[27:24] == RC_ACCEPT));

  // R10
  notimpl_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspData[27:24] == RC_NOTIMPL) |->
      ($stable(xport) && $stable(outMode) && $stable(inMode)));

  // R8
  stable_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspData[27:24] == RC_STABLE) |->
      ($stable(xport) && $stable(outMode) && $stable(inMode)));

  // R5
  reject_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rspValid && rspData[27:24] == RC_REJECT) |->
      ($stable(xport) && $stable(outMode) && $stable(inMode)));

endmodule

// File: rtl/avcVcrHandler.sv
module avcVcrHandler
  import avcVcrPkg::*;
#(
  parameter int                ADDR_W   = 48,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 48'hFFFF_F000_0B00,
  parameter logic [ADDR_W-1:0] RSP_ADDR = 48'hFFFF_F000_0D00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdWrValid,
  input  logic [ADDR_W-1:0] cmdWrAddr,
  input  logic [31:0]       cmdWrData,
  output logic              rspWrValid,
  output logic [ADDR_W-1:0] rspWrAddr,
  output logic [31:0]       rspWrData,
  output logic [2:0]        xportState,
  output logic [7:0]        outSignalMode,
  output logic [7:0]        inSignalMode
);

  ctrlStrobeT strb;
  xportE      xport;

  avcFrameCtrl #(
    .ADDR_W   (ADDR_W),
    .CMD_ADDR (CMD_ADDR)
  ) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrValid (cmdWrValid),
    .wrAddr  (cmdWrAddr),
    .wrData  (cmdWrData),
    .strb    (strb)
  );

  avcVcrDatapath #(
    .MODE_CNT (2)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .echoBytes (cmdWrData[23:8]),
    .operand   (cmdWrData[7:0]),
    .rspValid  (rspWrValid),
    .rspData   (rspWrData),
    .xport     (xport),
    .outMode   (outSignalMode),
    .inMode    (inSignalMode)
  );

  assign rspWrAddr  = RSP_ADDR;
  assign xportState = xport;

  // R2
  ignored_write_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdWrValid && (cmdWrAddr != CMD_ADDR || cmdWrData[31:28] != 4'h0)) |=>
      (!rspWrValid && $stable(xportState) && $stable(outSignalMode)
       && $stable(inSignalMode)));

  // R3
  response_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rspWrValid |-> $past(cmdWrValid));

endmodule

// File: tb/avcVcrHandler_tb_top.sv
module avcVcrHandler_tb_top;

  localparam logic [47:0] CMD_A = 48'hFFFF_F000_0B00;
  localparam logic [47:0] RSP_A = 48'hFFFF_F000_0D00;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdWrValid = 1'b0;
  logic [47:0] cmdWrAddr = '0;
  logic [31:0] cmdWrData = '0;
  logic        rspWrValid;
  logic [47:0] rspWrAddr;
  logic [31:0] rspWrData;
  logic [2:0]  xportState;
  logic [7:0]  outSignalMode;
  logic [7:0]  inSignalMode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  avcVcrHandler dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmdWrValid    (cmdWrValid),
    .cmdWrAddr     (cmdWrAddr),
    .cmdWrData     (cmdWrData),
    .rspWrValid    (rspWrValid),
    .rspWrAddr     (rspWrAddr),
    .rspWrData     (rspWrData),
    .xportState    (xportState),
    .outSignalMode (outSignalMode),
    .inSignalMode  (inSignalMode)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rsp(input logic [3:0] rc, input logic [31:0] cmd,
                                      input logic [7:0] op);
    return {4'h0, rc, cmd[23:8], op};
  endfunction

  // one write, then check the response and state in the following cycle
  task automatic sendCheck(input string req, input logic [47:0] addr, input logic [31:0] data,
                           input bit expRsp, input logic [31:0] expData,
                           input logic [2:0] expState);
    @(negedge clk);
    cmdWrValid = 1'b1;
    cmdWrAddr  = addr;
    cmdWrData  = data;
    @(negedge clk);
    cmdWrValid = 1'b0;
    check(req, rspWrValid, expRsp);
    if (expRsp) begin
      check(req, rspWrData, expData);
      check(req, rspWrAddr, RSP_A);
    end
    check(req, xportState, expState);
  endtask

  task automatic testReset();
    check("R1 state", xportState, 3'd0);
    check("R1 outMode", outSignalMode, 8'h80);
    check("R1 inMode", inSignalMode, 8'h80);
    check("R1 noRsp", rspWrValid, 1'b0);
  endtask

  task automatic testPlay();
    sendCheck("R4 play x1", CMD_A, 32'h0020C338, 1, rsp(4'h9, 32'h0020C338, 8'h38), 3'd1);
    sendCheck("R4 play bad", CMD_A, 32'h0020C339, 1, rsp(4'hA, 32'h0020C339, 8'h39), 3'd1);
  endtask

  task automatic testRecord();
    sendCheck("R5 rec bad", CMD_A, 32'h0020C238, 1, rsp(4'hA, 32'h0020C238, 8'h38), 3'd1);
    sendCheck("R5 rec x1", CMD_A, 32'h0020C275, 1, rsp(4'h9, 32'h0020C275, 8'h75), 3'd2);
  endtask

  task automatic testWind();
    sendCheck("R6 rewind", CMD_A, 32'h0020C465, 1, rsp(4'h9, 32'h0020C465, 8'h65), 3'd3);
    sendCheck("R6 ffwd", CMD_A, 32'h0020C475, 1, rsp(4'h9, 32'h0020C475, 8'h75), 3'd4);
    sendCheck("R6 bad", CMD_A, 32'h0020C461, 1, rsp(4'hA, 32'h0020C461, 8'h61), 3'd4);
    sendCheck("R6 stop", CMD_A, 32'h0020C460, 1, rsp(4'h9, 32'h0020C460, 8'h60), 3'd0);
  endtask

  task automatic testModes();
    sendCheck("R7 out 90", CMD_A, 32'h00207890, 1, rsp(4'h9, 32'h00207890, 8'h90), 3'd0);
    check("R7 outMode", outSignalMode, 8'h90);
    check("R7 inMode kept", inSignalMode, 8'h80);
    sendCheck("R7 in 14", CMD_A, 32'h00207914, 1, rsp(4'h9, 32'h00207914, 8'h14), 3'd0);
    check("R7 inMode", inSignalMode, 8'h14);
    sendCheck("R7 out bad", CMD_A, 32'h00207881, 1, rsp(4'hA, 32'h00207881, 8'h81), 3'd0);
    check("R7 outMode kept", outSignalMode, 8'h90);
  endtask

  task automatic testModeStatus();
    sendCheck("R8 out status", CMD_A, 32'h012078FF, 1, rsp(4'hC, 32'h012078FF, 8'h90), 3'd0);
    sendCheck("R8 in status", CMD_A, 32'h012079FF, 1, rsp(4'hC, 32'h012079FF, 8'h14), 3'd0);
    check("R8 outMode kept", outSignalMode, 8'h90);
  endtask

  task automatic testUnitInfo();
    sendCheck("R9 unit", CMD_A, 32'h01FF30FF, 1, rsp(4'hC, 32'h01FF30FF, 8'h20), 3'd0);
    sendCheck("R9 subunit", CMD_A, 32'h01FF3107, 1, rsp(4'hC, 32'h01FF3107, 8'h20), 3'd0);
  endtask

  task automatic testNotImpl();
    sendCheck("R10 opcode", CMD_A, 32'h00205512, 1, rsp(4'h8, 32'h00205512, 8'h12), 3'd0);
    sendCheck("R10 subunit", CMD_A, 32'h0021C338, 1, rsp(4'h8, 32'h0021C338, 8'h38), 3'd0);
    sendCheck("R10 ctype", CMD_A, 32'h0120C338, 1, rsp(4'h8, 32'h0120C338, 8'h38), 3'd0);
    sendCheck("R10 unit ctl", CMD_A, 32'h00FF30FF, 1, rsp(4'h8, 32'h00FF30FF, 8'hFF), 3'd0);
    sendCheck("R10 mode ct2", CMD_A, 32'h02207810, 1, rsp(4'h8, 32'h02207810, 8'h10), 3'd0);
    check("R10 outMode kept", outSignalMode, 8'h90);
  endtask

  task automatic testIgnored();
    sendCheck("R2 set code", CMD_A, 32'h1020C338, 0, 32'h0, 3'd0);
    sendCheck("R2 rsp addr", RSP_A, 32'h0020C338, 0, 32'h0, 3'd0);
    sendCheck("R2 other addr", CMD_A + 48'd4, 32'h00207810, 0, 32'h0, 3'd0);
    check("R2 outMode kept", outSignalMode, 8'h90);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    cmdWrValid = 1'b1;
    cmdWrAddr  = CMD_A;
    cmdWrData  = 32'h0020C338;
    @(negedge clk);
    check("R3 b2b first", rspWrData, rsp(4'h9, 32'h0020C338, 8'h38));
    check("R3 b2b state1", xportState, 3'd1);
    cmdWrData  = 32'h0020C465;
    @(negedge clk);
    cmdWrValid = 1'b0;
    check("R3 b2b valid", rspWrValid, 1'b1);
    check("R3 b2b second", rspWrData, rsp(4'h9, 32'h0020C465, 8'h65));
    check("R3 b2b state2", xportState, 3'd3);
    @(negedge clk);
    check("R3 single pulse", rspWrValid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testPlay();
    testRecord();
    testWind();
    testModes();
    testModeStatus();
    testUnitInfo();
    testNotImpl();
    testIgnored();
    testBackToBack();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule